// File: doc/BRIEF.md
# Channel Gain and Offset Trim Datapath

This block sits between a channel's stored output code and the converter core. Each accepted sample is corrected by two calibration trims. The first is a gain trim, which stretches or shrinks the code's distance from mid-scale. The second is an offset trim, which shifts the whole transfer curve in eighth-LSB steps.

The input may use offset-binary or two's-complement coding. The block works internally in offset binary and returns the result in the coding it received. Results beyond the 16-bit range saturate, and a flag reports each saturation. A 2-bit span selector travels alongside the code and is registered with it, so that the analog range switch downstream sees the matching span index.

A sample is taken when `in_valid` is high. Its corrected result appears on the outputs one clock later, and the outputs hold until the next accepted sample.

Top module: `dac_trim`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `out_code`, `out_clamped` and `out_range` are all zero until the first accepted sample.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_code`, `out_range` and `out_clamped` keep their values.
- R3: With `gain_code` = 6'b011111 and `ofs_code` = 8'h7F, `out_code` equals `in_code` for every code in both codings, and `out_clamped` is low.
- R4: With `twos_comp` = 1, bit 15 of the input is inverted before correction and bit 15 of the result is inverted after it. Code 0x8000 is therefore negative full scale and 0x0000 is mid-scale. With `twos_comp` = 0, code 0x0000 is negative full scale and 0x8000 is mid-scale.
- R5: The gain trim in LSB is G = 31 − `gain_code`, read as an unsigned number. Code 0 gives +31 and code 63 gives −32. The offset-binary value u is moved by floor((G·(u − 32768) + 16384) / 32768).
- R6: The offset trim in eighth-LSB is F = 127 − `ofs_code`, read as an unsigned number. Code 0x00 gives +127/8 and code 0xFF gives −128/8. The pre-clamp result is floor((8·u + 8·gain term + F + 4) / 8), which rounds halves upward.
- R7: A pre-clamp result below 0 gives offset-binary 0x0000, and one above 65535 gives 0xFFFF. `out_clamped` is high exactly when one of these happens.
- R8: `out_range` takes `range_sel` from the accepted sample. Values 2'b00, 2'b01 and 2'b10 pass unchanged, and the reserved value 2'b11 is forwarded as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_code | input | 16 | Channel code |
| twos_comp | input | 1 | 1: two's-complement coding, 0: offset binary |
| gain_code | input | 6 | Gain trim, descending encoding |
| ofs_code | input | 8 | Offset trim, descending encoding |
| range_sel | input | 2 | Span select |
| out_valid | output | 1 | Result strobe |
| out_code | output | 16 | Corrected code, in the input's coding |
| out_range | output | 2 | Registered span index |
| out_clamped | output | 1 | Result was saturated |

## Verification
The hardest situation to reach is a result that lands exactly on the rails, or just past them. There the rounded gain term and the rounded offset term together decide whether saturation happens. The stimulus sweeps every gain code and every offset code against input codes packed near both ends of the scale and around mid-scale, in both codings. This covers the sign change of the deviation and the half-LSB rounding ties. The gain-trim and offset-trim results are compared with a reference that uses plain integer arithmetic.

// File: rtl/dac_trim.sv
module dac_trim (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_code,
  input  logic        twos_comp,
  input  logic [5:0]  gain_code,
  input  logic [7:0]  ofs_code,
  input  logic [1:0]  range_sel,
  output logic        out_valid,
  output logic [15:0] out_code,
  output logic [1:0]  out_range,
  output logic        out_clamped
);

  logic [15:0]        u;
  logic signed [15:0] dev;
  logic signed [5:0]  g_s;
  logic signed [7:0]  f_s;
  logic signed [21:0] prod, g_rnd, g_adj, acc, res;
  logic               under, over;
  logic [15:0]        sat;

  // offset-binary value and its signed distance from mid-scale
  assign u     = {in_code[15] ^ twos_comp, in_code[14:0]};
  assign dev   = $signed({~u[15], u[14:0]});
  // descending encodings: 31 - g and 127 - o
  assign g_s   = $signed({gain_code[5], ~gain_code[4:0]});
  assign f_s   = $signed({ofs_code[7], ~ofs_code[6:0]});

  assign prod  = 22'(g_s) * 22'(dev);
  assign g_rnd = prod + 22'sd16384;
  assign g_adj = g_rnd >>> 15;

  assign acc   = $signed({3'b000, u, 3'b000}) + (g_adj <<< 3) + 22'(f_s) + 22'sd4;
  assign res   = acc >>> 3;

  assign under = res[21];
  assign over  = !res[21] && (|res[20:16]);
  assign sat   = under ? 16'h0000 : (over ? 16'hFFFF : res[15:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_code    <= '0;
      out_range   <= '0;
      out_clamped <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code    <= {sat[15] ^ twos_comp, sat[14:0]};
        out_range   <= (range_sel == 2'b11) ? 2'b00 : range_sel;
        out_clamped <= under | over;
      end
    end
  end

endmodule

// File: rtl/dac_trim_chk.sv
module dac_trim_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_code,
  input logic        twos_comp,
  input logic [5:0]  gain_code,
  input logic [7:0]  ofs_code,
  input logic [1:0]  range_sel,
  input logic        out_valid,
  input logic [15:0] out_code,
  input logic [1:0]  out_range,
  input logic        out_clamped
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_code) && $stable(out_range) && $stable(out_clamped));

  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain_code == 6'b011111 && ofs_code == 8'h7F)
      |=> (out_code == $past(in_code)) && !out_clamped);

  a_r7_clamp_at_rail: assert property (@(posedge clk) disable iff (!rst_n)
    out_clamped |-> (out_code[14:0] == 15'h0000 || out_code[14:0] == 15'h7FFF));

  a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    out_range != 2'b11);

endmodule

bind dac_trim dac_trim_chk u_chk (.*);

// File: tb/sim_dac_trim.sv
module sim_dac_trim;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_code = '0;
  logic        twos_comp = 1'b0;
  logic [5:0]  gain_code = 6'b011111;
  logic [7:0]  ofs_code = 8'h7F;
  logic [1:0]  range_sel = 2'b00;
  logic        out_valid;
  logic [15:0] out_code;
  logic [1:0]  out_range;
  logic        out_clamped;

  int nvec = 0;
  int nbad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  dac_trim u0 (.*);

  function automatic void ref_calc(input int code, input int tc, input int g, input int o,
                                   output int oc, output int fl);
    int u, d, gg, p, ga, s8, r;
    u  = tc ? (code ^ 32'h8000) : code;
    d  = u - 32768;
    gg = 31 - g;
    p  = gg * d;
    ga = (p + 16384) >>> 15;
    s8 = u * 8 + ga * 8 + (127 - o) + 4;
    r  = s8 >>> 3;
    fl = (r < 0 || r > 65535) ? 1 : 0;
    if (r < 0) r = 0;
    if (r > 65535) r = 65535;
    oc = tc ? (r ^ 32'h8000) : r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  int last_code = 0;

  // caller stands at a negedge; after return it stands at the next negedge
  task automatic vec(input string tag, input int code, input int tc, input int g,
                     input int o, input int rs);
    int ec, ef;
    ref_calc(code, tc, g, o, ec, ef);
    in_valid  = 1'b1;
    in_code   = 16'(code);
    twos_comp = tc[0];
    gain_code = 6'(g);
    ofs_code  = 8'(o);
    range_sel = 2'(rs);
    @(negedge clk);
    check(tag, int'(out_code), ec);
    check(tag, int'(out_clamped), ef);
    check("R2", int'(out_valid), 1);
    check("R8", int'(out_range), (rs == 3) ? 0 : rs);
    last_code = ec;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_code), 0);
    check("R1", int'(out_clamped), 0);
    check("R1", int'(out_range), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_code), 0);

    // R3: identity over every code, offset binary
    for (int c = 0; c < 65536; c++) vec("R3", c, 0, 31, 127, c % 3);
    // R3/R4: identity in two's complement, strided
    for (int c = 0; c < 65536; c += 7) vec("R4", c, 1, 31, 127, 1);

    // R5: every gain code against chosen codes, both codings
    for (int g = 0; g < 64; g++)
      for (int k = 0; k < 32; k++) begin
        int c;
        c = (k < 8) ? k : (k < 16) ? 32760 + k : (k < 24) ? 65535 - (k - 16) : k * 2039;
        vec("R5", c, k % 2, g, 127, 2);
      end

    // R6: every offset code against chosen codes, both codings
    for (int o = 0; o < 256; o++)
      for (int k = 0; k < 16; k++) begin
        int c;
        c = (k < 4) ? k * 5 : (k < 8) ? 65535 - k * 5 : (k < 12) ? 32766 + k : k * 4001;
        vec("R6", c, k / 8, 31, o, 0);
      end

    // R7: both rails with the extreme trims, both codings
    for (int tc = 0; tc < 2; tc++)
      for (int e = 0; e < 4; e++) begin
        int base;
        base = tc ? 32'h8000 : 0;
        vec("R7", (base + e) & 32'hFFFF, tc, 63, 255, 0);
        vec("R7", (base + 65535 - e) & 32'hFFFF, tc, 0, 0, 0);
        vec("R7", (base + 65535 - e) & 32'hFFFF, tc, 63, 0, 1);
        vec("R7", (base + e) & 32'hFFFF, tc, 0, 255, 1);
      end

    // R8: every span value including reserved
    for (int rs = 0; rs < 4; rs++) vec("R8", 1234 * rs, 0, 20, 90, rs);

    // R2: outputs hold while strobe is low
    vec("R2", 40000, 0, 10, 50, 2);
    in_valid  = 1'b0;
    in_code   = 16'h1357;
    gain_code = 6'd63;
    ofs_code  = 8'hFF;
    range_sel = 2'b01;
    @(negedge clk);
    check("R2", int'(out_valid), 0);
    check("R2", int'(out_code), last_code);
    check("R2", int'(out_range), 2);
    @(negedge clk);
    check("R2", int'(out_code), last_code);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule